// File: doc/BRIEF.md
# Shared QSPI Memory Controller

This block connects a CPU-side load/store port to one set of QSPI clock and data lines. Three memories share those lines: a read-only flash and two PSRAM devices, and each memory has its own chip select. The controller decodes a 28-bit byte address, picks the memory and opens a transaction with a nibble header. For flash the header is the address plus a mode byte that keeps the flash in continuous-read mode. For PSRAM it is a command byte plus the address. The controller then moves 1, 2 or 4 bytes four bits at a time and ends the access with a one-cycle `done` pulse.

The memories are expected to come out of reset already configured. The flash is in continuous-read mode and both PSRAMs are in quad command mode. The number of wait slots between the header and the read data is taken from the two low data pins while reset is held. A request is rejected without any bus activity if it writes to flash or targets an address outside the three memory windows. A rejected request completes at once with an error flag.

Top module: `qspi_mem_ctrl`

## Requirements
- R1: Addresses 0x0000000 to 0x0FFFFFF select the flash chip select. Addresses 0x1000000 to 0x17FFFFF select RAM A and 0x1800000 to 0x1FFFFFF select RAM B. Any other address gets no chip select and finishes with `done` and `err` in the cycle after acceptance.
- R2: At most one chip select is low in any cycle. While all chip selects are high, `qspi_sck` and `qspi_oe` are low.
- R3: A write to the flash window never lowers a chip select. It finishes with `done` and `err` high in the cycle after acceptance.
- R4: While `rst` is high, all chip selects are high, `qspi_oe` is low and `busy` is low. The read wait-slot count (0 to 3) is the value of `qspi_din[1:0]` at the last clock edge with `rst` high.
- R5: A flash read drives address bits 23:0 as six nibbles, most significant first, then the mode byte 0xA0 as two nibbles. It then has L slots with `qspi_oe` low, where L is the latched count, followed by the data slots. No command byte is sent.
- R6: A PSRAM read drives command 0xEB as two nibbles, then the offset within the selected RAM as six nibbles. The offset is address bits 22:0 with a zero on top. L wait slots with `qspi_oe` low follow before the data slots.
- R7: A PSRAM write drives command 0x38, the six offset nibbles and then the data nibbles, all with `qspi_oe` high and with no wait slots.
- R8: `req_size` 0 moves one byte, 1 moves two bytes, and 2 or 3 move four bytes. Byte 0 (`req_wdata[7:0]` or `rdata[7:0]`) travels first and the high nibble of each byte precedes its low nibble. Unread upper bytes of `rdata` are zero.
- R9: Every nibble slot lasts two clocks: one with `qspi_sck` low, in which the controller changes its output, and one with `qspi_sck` high. Read data is sampled at the edge that ends the high clock. An access of S slots raises `done` 2*S clocks after the edge that accepts it.
- R10: `busy` is high from the cycle after acceptance through the `done` cycle. `done` lasts exactly one cycle, with all chip selects high. `req_valid` has no effect while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also the wait-slot capture window |
| req_valid | input | 1 | Request strobe, accepted when `busy` is low |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 28 | Byte address |
| req_size | input | 2 | Transfer size code (see R8) |
| req_wdata | input | 32 | Write data, byte 0 in bits 7:0 |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Request rejected, valid with `done` |
| rdata | output | 32 | Read data, valid with `done` |
| qspi_sck | output | 1 | Serial clock shared by all memories |
| qspi_cs_flash_n | output | 1 | Flash chip select, active low |
| qspi_cs_rama_n | output | 1 | RAM A chip select, active low |
| qspi_cs_ramb_n | output | 1 | RAM B chip select, active low |
| qspi_dout | output | 4 | Data driven toward the memories |
| qspi_oe | output | 1 | Output enable for `qspi_dout` |
| qspi_din | input | 4 | Data returned by the memories; wait-slot count on bits 1:0 during reset |

## Verification
The properties assume that no request is presented while reset is high. They also assume that the memory side changes `qspi_din` only after a rising `qspi_sck`, so the value is stable at the next sampling edge. The bench holds each request for a single clock, driven at the falling edge. A memory model answers only during read data slots and computes which nibble to return from its own slot count and the wait-slot count it forced during reset. Stray requests are presented only while `busy` is high and are withdrawn before `done`, so any acceptance of them would show up as an extra chip-select period.

// File: rtl/qmc_pkg.sv
`timescale 1ns/1ps
package qmc_pkg;
  typedef enum logic [1:0] {
    DEV_NONE  = 2'd0,
    DEV_FLASH = 2'd1,
    DEV_RAMA  = 2'd2,
    DEV_RAMB  = 2'd3
  } dev_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_DONE  = 2'd2
  } st_e;

  localparam logic [7:0] PSRAM_RD_CMD    = 8'hEB;
  localparam logic [7:0] PSRAM_WR_CMD    = 8'h38;
  localparam logic [7:0] FLASH_MODE_BYTE = 8'hA0;
endpackage

// File: rtl/qmc_decode.sv
`timescale 1ns/1ps
module qmc_decode
  import qmc_pkg::*;
#(
  parameter int ADDR_W = 28,
  parameter int DEV_AW = 24
) (
  input  logic [ADDR_W-1:0] addr,
  output dev_e              dev,
  output logic [DEV_AW-1:0] dev_addr
);
  localparam int HI_W   = ADDR_W - DEV_AW;
  localparam int RAM_AW = DEV_AW - 1;

  always_comb begin
    dev      = DEV_NONE;
    dev_addr = '0;
    if (addr[ADDR_W-1:DEV_AW] == HI_W'(0)) begin
      dev      = DEV_FLASH;
      dev_addr = addr[DEV_AW-1:0];
    end else if (addr[ADDR_W-1:DEV_AW] == HI_W'(1)) begin
      // upper half of the 16 MB window is the second RAM
      dev      = addr[RAM_AW] ? DEV_RAMB : DEV_RAMA;
      dev_addr = {1'b0, addr[RAM_AW-1:0]};
    end
  end
endmodule

// File: rtl/qmc_rxpack.sv
`timescale 1ns/1ps
module qmc_rxpack #(
  parameter int DATA_W = 32,
  parameter int NIB_W  = $clog2(DATA_W/4)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              en,
  input  logic [NIB_W-1:0]  idx,
  input  logic [3:0]        nib,
  output logic [DATA_W-1:0] data
);
  // nibble k lands in byte k/2; even k is the high half of that byte
  logic [NIB_W+1:0] base;
  always_comb base = {idx[NIB_W-1:1], ~idx[0], 2'b00};

  always_ff @(posedge clk) begin
    if (rst || clear)
      data <= '0;
    else if (en)
      data[base +: 4] <= nib;
  end
endmodule

// File: rtl/qmc_seq.sv
`timescale 1ns/1ps
module qmc_seq
  import qmc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEV_AW = 24,
  parameter int LAT_W  = 2,
  parameter int NIB_W  = $clog2(DATA_W/4)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  dev_e              dev,
  input  logic [DEV_AW-1:0] dev_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [LAT_W-1:0]  lat_pins,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [2:0]        cs_n,
  output logic              sck,
  output logic [3:0]        sd_out,
  output logic              sd_oe,
  output logic              rx_clear,
  output logic              rx_en,
  output logic [NIB_W-1:0]  rx_idx
);
  localparam int HDR_W    = 8 + DEV_AW;
  localparam int HDR_NIBS = HDR_W / 4;
  localparam int NBYTES   = DATA_W / 8;
  localparam int SH_W     = HDR_W + DATA_W;
  localparam int SLOT_W   = $clog2(HDR_NIBS + (1 << LAT_W) + DATA_W/4 + 1);

  st_e               state;
  logic              ph;
  logic              wr;
  logic [LAT_W-1:0]  lat;
  logic [SLOT_W-1:0] slot, last, dstart;
  logic [SH_W-1:0]   sh;

  logic [DATA_W-1:0] wstream;
  logic [HDR_W-1:0]  hdr;
  logic [SLOT_W-1:0] ndat, dstart_n, next_slot;
  logic [2:0]        cs_sel;
  logic              illegal, accept;

  // byte 0 goes out first: reverse byte order into the stream
  genvar b;
  generate
    for (b = 0; b < NBYTES; b++) begin : g_swap
      assign wstream[DATA_W-1-8*b -: 8] = req_wdata[8*b +: 8];
    end
  endgenerate

  always_comb begin
    case (req_size)
      2'd0:    ndat = SLOT_W'(2);
      2'd1:    ndat = SLOT_W'(4);
      default: ndat = SLOT_W'(DATA_W/4);
    endcase
    if (dev == DEV_FLASH)
      hdr = {dev_addr, FLASH_MODE_BYTE};
    else
      hdr = {(req_write ? PSRAM_WR_CMD : PSRAM_RD_CMD), dev_addr};
    case (dev)
      DEV_FLASH: cs_sel = 3'b110;
      DEV_RAMA:  cs_sel = 3'b101;
      DEV_RAMB:  cs_sel = 3'b011;
      default:   cs_sel = 3'b111;
    endcase
    dstart_n  = req_write ? SLOT_W'(HDR_NIBS) : SLOT_W'(HDR_NIBS) + SLOT_W'(lat);
    illegal   = (dev == DEV_NONE) || ((dev == DEV_FLASH) && req_write);
    accept    = (state == ST_IDLE) && req_valid;
    next_slot = slot + 1'b1;
  end

  assign busy     = (state != ST_IDLE);
  assign sck      = ph;
  assign sd_out   = sh[SH_W-1 -: 4];
  assign rx_clear = accept;
  assign rx_en    = (state == ST_SHIFT) && ph && !wr && (slot >= dstart);
  assign rx_idx   = NIB_W'(slot - dstart);

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      ph     <= 1'b0;
      wr     <= 1'b0;
      cs_n   <= '1;
      sd_oe  <= 1'b0;
      done   <= 1'b0;
      err    <= 1'b0;
      slot   <= '0;
      last   <= '0;
      dstart <= '0;
      sh     <= '0;
      lat    <= lat_pins;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            if (illegal) begin
              state <= ST_DONE;
              done  <= 1'b1;
              err   <= 1'b1;
            end else begin
              state  <= ST_SHIFT;
              ph     <= 1'b0;
              slot   <= '0;
              wr     <= req_write;
              sd_oe  <= 1'b1;
              dstart <= dstart_n;
              last   <= dstart_n + ndat - 1'b1;
              sh     <= {hdr, wstream};
              cs_n   <= cs_sel;
            end
          end
        end
        ST_SHIFT: begin
          if (!ph) begin
            ph <= 1'b1;
          end else begin
            ph <= 1'b0;
            if (sd_oe)
              sh <= {sh[SH_W-5:0], 4'h0};
            if (slot == last) begin
              state <= ST_DONE;
              cs_n  <= '1;
              sd_oe <= 1'b0;
              done  <= 1'b1;
            end else begin
              slot  <= next_slot;
              sd_oe <= wr || (next_slot < SLOT_W'(HDR_NIBS));
            end
          end
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/qspi_mem_ctrl.sv
`timescale 1ns/1ps
module qspi_mem_ctrl
  import qmc_pkg::*;
#(
  parameter int ADDR_W = 28,
  parameter int DATA_W = 32,
  parameter int DEV_AW = 24,
  parameter int LAT_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [DATA_W-1:0] rdata,
  output logic              qspi_sck,
  output logic              qspi_cs_flash_n,
  output logic              qspi_cs_rama_n,
  output logic              qspi_cs_ramb_n,
  output logic [3:0]        qspi_dout,
  output logic              qspi_oe,
  input  logic [3:0]        qspi_din
);
  localparam int NIB_W = $clog2(DATA_W/4);

  dev_e              dev;
  logic [DEV_AW-1:0] dev_addr;
  logic [2:0]        cs_n;
  logic              rx_clear, rx_en;
  logic [NIB_W-1:0]  rx_idx;

  qmc_decode #(.ADDR_W(ADDR_W), .DEV_AW(DEV_AW)) u_decode (
    .addr     (req_addr),
    .dev      (dev),
    .dev_addr (dev_addr)
  );

  qmc_seq #(.DATA_W(DATA_W), .DEV_AW(DEV_AW), .LAT_W(LAT_W), .NIB_W(NIB_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_size  (req_size),
    .dev       (dev),
    .dev_addr  (dev_addr),
    .req_wdata (req_wdata),
    .lat_pins  (qspi_din[LAT_W-1:0]),
    .busy      (busy),
    .done      (done),
    .err       (err),
    .cs_n      (cs_n),
    .sck       (qspi_sck),
    .sd_out    (qspi_dout),
    .sd_oe     (qspi_oe),
    .rx_clear  (rx_clear),
    .rx_en     (rx_en),
    .rx_idx    (rx_idx)
  );

  qmc_rxpack #(.DATA_W(DATA_W), .NIB_W(NIB_W)) u_rxpack (
    .clk   (clk),
    .rst   (rst),
    .clear (rx_clear),
    .en    (rx_en),
    .idx   (rx_idx),
    .nib   (qspi_din),
    .data  (rdata)
  );

  assign qspi_cs_flash_n = cs_n[0];
  assign qspi_cs_rama_n  = cs_n[1];
  assign qspi_cs_ramb_n  = cs_n[2];
endmodule

// File: rtl/qmc_check.sv
`timescale 1ns/1ps
module qmc_check (
  input logic       clk,
  input logic       rst,
  input logic       req_valid,
  input logic       req_write,
  input logic [4:0] addr_hi,
  input logic       busy,
  input logic       done,
  input logic       err,
  input logic       sck,
  input logic       cs_f_n,
  input logic       cs_a_n,
  input logic       cs_b_n,
  input logic       oe
);
  logic all_high, take;
  assign all_high = cs_f_n && cs_a_n && cs_b_n;
  assign take     = req_valid && !busy;

  AST_ONE_CS: assert property (@(posedge clk) disable iff (rst)
    $countones({~cs_f_n, ~cs_a_n, ~cs_b_n}) <= 1); // R2
  AST_BUS_QUIET: assert property (@(posedge clk) disable iff (rst)
    all_high |-> (!sck && !oe)); // R2
  AST_RESET_SAFE: assert property (@(posedge clk)
    rst |=> (all_high && !oe && !busy)); // R4
  AST_FLASH_WRITE_REJECT: assert property (@(posedge clk) disable iff (rst)
    (take && req_write && addr_hi[4:1] == 4'd0) |=> (done && err && all_high)); // R3
  AST_UNMAPPED_REJECT: assert property (@(posedge clk) disable iff (rst)
    (take && addr_hi[4:2] != 3'd0) |=> (done && err && all_high)); // R1
  AST_RAMA_SELECT: assert property (@(posedge clk) disable iff (rst)
    (take && addr_hi == 5'b00010) |=> (!cs_a_n && cs_f_n && cs_b_n)); // R1
  AST_RAMB_SELECT: assert property (@(posedge clk) disable iff (rst)
    (take && addr_hi == 5'b00011) |=> (!cs_b_n && cs_f_n && cs_a_n)); // R1
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R10
  AST_DONE_RELEASED: assert property (@(posedge clk) disable iff (rst)
    done |-> (all_high && busy)); // R10
  AST_BUSY_ENDS_ON_DONE: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(done)); // R10
  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    err |-> done); // R3
endmodule

bind qspi_mem_ctrl qmc_check u_check (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_write (req_write),
  .addr_hi   (req_addr[27:23]),
  .busy      (busy),
  .done      (done),
  .err       (err),
  .sck       (qspi_sck),
  .cs_f_n    (qspi_cs_flash_n),
  .cs_a_n    (qspi_cs_rama_n),
  .cs_b_n    (qspi_cs_ramb_n),
  .oe        (qspi_oe)
);

// File: tb/qspi_mem_ctrl_test.sv
`timescale 1ns/1ps
module qspi_mem_ctrl_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [27:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic [31:0] req_wdata = '0;
  logic        busy, done, err;
  logic [31:0] rdata;
  logic        qspi_sck, qspi_cs_flash_n, qspi_cs_rama_n, qspi_cs_ramb_n, qspi_oe;
  logic [3:0]  qspi_dout;
  logic [3:0]  qspi_din = 4'h0;

  always #10 clk = ~clk;

  qspi_mem_ctrl uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .busy(busy), .done(done), .err(err), .rdata(rdata),
    .qspi_sck(qspi_sck), .qspi_cs_flash_n(qspi_cs_flash_n),
    .qspi_cs_rama_n(qspi_cs_rama_n), .qspi_cs_ramb_n(qspi_cs_ramb_n),
    .qspi_dout(qspi_dout), .qspi_oe(qspi_oe), .qspi_din(qspi_din)
  );

  int checks = 0;
  int errors = 0;

  // memory model state
  int          slot_n;
  int          nout;
  int          nlow;
  logic [3:0]  outlog [0:31];
  logic [2:0]  cs_seen;
  int          cur_lat;
  bit          cur_rd;
  logic [31:0] resp;

  always @(posedge qspi_sck) begin
    cs_seen = cs_seen | ~{qspi_cs_ramb_n, qspi_cs_rama_n, qspi_cs_flash_n};
    if (qspi_oe) begin
      if (nout < 32) outlog[nout] = qspi_dout;
      nout++;
    end else begin
      nlow++;
    end
    if (cur_rd && slot_n >= 8 + cur_lat) begin
      int d;
      d = slot_n - 8 - cur_lat;
      qspi_din = resp[(d/2)*8 + ((d%2 != 0) ? 0 : 4) +: 4];
    end
    slot_n++;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] pack8(input int from);
    logic [31:0] v = '0;
    for (int i = 0; i < 8; i++) v = {v[27:0], outlog[from + i]};
    return v;
  endfunction

  function automatic logic [31:0] size_mask(input logic [1:0] sz);
    case (sz)
      2'd0:    return 32'h0000_00FF;
      2'd1:    return 32'h0000_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic int nbytes(input logic [1:0] sz);
    return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
  endfunction

  task automatic model_clear();
    slot_n = 0; nout = 0; nlow = 0; cs_seen = 3'b000;
  endtask

  task automatic do_reset(input int lat);
    @(negedge clk);
    rst = 1'b1;
    qspi_din = 4'(lat);
    repeat (3) @(negedge clk);
    chk({qspi_cs_flash_n, qspi_cs_rama_n, qspi_cs_ramb_n} == 3'b111 && !qspi_oe && !busy,
        "R4", "bus idle in reset", {28'h0, qspi_cs_flash_n, qspi_cs_rama_n, qspi_cs_ramb_n, qspi_oe},
        32'he);
    rst = 1'b0;
    @(negedge clk);
    qspi_din = 4'h0;
    cur_lat = lat;
    chk(!busy && !done, "R4", "idle after reset", {30'h0, busy, done}, 32'h0);
  endtask

  task automatic run(input bit w, input logic [27:0] a, input logic [1:0] sz,
                     input logic [31:0] wd, output int k, output logic e, output logic [31:0] rd);
    model_clear();
    cur_rd = !w;
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_size = sz; req_wdata = wd;
    k = 0;
    do begin
      @(negedge clk);
      k++;
      req_valid = 1'b0;
    end while (!done && k < 1000);
    e  = err;
    rd = rdata;
    @(negedge clk);
    chk(!done, "R10", "done lasts one cycle", {31'h0, done}, 32'h0);
  endtask

  task automatic t_flash_read(input int lat, input logic [27:0] a, input logic [31:0] r);
    int k; logic e; logic [31:0] rd;
    resp = r;
    run(1'b0, a, 2'd2, 32'h0, k, e, rd);
    chk(cs_seen == 3'b001, "R1", "flash select", {29'h0, cs_seen}, 32'h1);
    chk(pack8(0) == {a[23:0], 8'hA0}, "R5", "flash header", pack8(0), {a[23:0], 8'hA0});
    chk(nout == 8 && nlow == lat + 8, "R5", "flash wait and data slots", nlow, lat + 8);
    chk(rd == r && !e, "R8", "flash read data", rd, r);
    chk(k == 2 * (16 + lat) + 1, "R9", "flash read duration", k, 2 * (16 + lat) + 1);
  endtask

  task automatic t_ram_read(input int lat, input logic [27:0] a, input logic [1:0] sz,
                            input logic [31:0] r);
    int k; logic e; logic [31:0] rd; int s;
    logic [2:0] exp_cs;
    resp = r;
    exp_cs = a[23] ? 3'b100 : 3'b010;
    s = 8 + lat + 2 * nbytes(sz);
    run(1'b0, a, sz, 32'h0, k, e, rd);
    chk(cs_seen == exp_cs, "R1", "ram select", {29'h0, cs_seen}, {29'h0, exp_cs});
    chk(pack8(0) == {8'hEB, 1'b0, a[22:0]}, "R6", "ram read header", pack8(0),
        {8'hEB, 1'b0, a[22:0]});
    chk(nout == 8 && nlow == s - 8, "R6", "ram read wait and data slots", nlow, s - 8);
    chk(rd == (r & size_mask(sz)) && !e, "R8", "ram read data", rd, r & size_mask(sz));
    chk(slot_n == s && k == 2 * s + 1, "R9", "ram read duration", k, 2 * s + 1);
  endtask

  task automatic t_ram_write(input logic [27:0] a, input logic [1:0] sz, input logic [31:0] wd);
    int k; logic e; logic [31:0] rd; int n;
    logic [31:0] exp_stream, act_stream;
    n = 2 * nbytes(sz);
    exp_stream = {wd[7:0], wd[15:8], wd[23:16], wd[31:24]};
    exp_stream = exp_stream & ~(32'hFFFF_FFFF >> (4 * n));
    act_stream = '0;
    run(1'b1, a, sz, wd, k, e, rd);
    for (int i = 0; i < 8; i++)
      act_stream = {act_stream[27:0], (i < n) ? outlog[8 + i] : 4'h0};
    chk(pack8(0) == {8'h38, 1'b0, a[22:0]}, "R7", "ram write header", pack8(0),
        {8'h38, 1'b0, a[22:0]});
    chk(nlow == 0 && nout == 8 + n, "R7", "write slots all driven", nout, 8 + n);
    chk(act_stream == exp_stream, "R8", "write nibble order", act_stream, exp_stream);
    chk(k == 2 * (8 + n) + 1 && !e, "R9", "write duration", k, 2 * (8 + n) + 1);
  endtask

  task automatic t_reject(input bit w, input logic [27:0] a, input string req);
    int k; logic e; logic [31:0] rd;
    run(w, a, 2'd2, 32'hCAFE_F00D, k, e, rd);
    repeat (6) @(negedge clk);
    chk(k == 1 && e, req, "rejected with err next cycle", k, 1);
    chk(cs_seen == 3'b000 && nout == 0, req, "no bus activity", {29'h0, cs_seen}, 32'h0);
  endtask

  task automatic t_busy_ignore();
    int k; logic e;
    model_clear();
    cur_rd = 1'b1;
    resp = 32'h0000_0077;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 28'h1000040; req_size = 2'd0;
    k = 0;
    do begin
      @(negedge clk);
      k++;
      if (k == 2) chk(busy, "R10", "busy during access", {31'h0, busy}, 32'h1);
      // stray requests while busy: RAM B write and flash write
      req_valid = (k >= 1 && k <= 5);
      req_write = 1'b1;
      req_addr  = (k < 3) ? 28'h1800000 : 28'h0000010;
    end while (!done && k < 1000);
    e = err;
    req_valid = 1'b0;
    repeat (12) @(negedge clk);
    chk(cs_seen == 3'b010 && !e, "R10", "stray request ignored", {29'h0, cs_seen}, 32'h2);
    chk(nout == 8 && !busy, "R10", "no extra access", nout, 8);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    model_clear();
    cur_lat = 0; cur_rd = 1'b0; resp = '0;
    do_reset(2);
    t_flash_read(2, 28'h0A5C3E1, 32'h8899_AABB);
    t_ram_read(2, 28'h1234567, 2'd0, 32'hDEAD_BE5A);
    t_ram_read(2, 28'h1FEDCBA, 2'd1, 32'h1357_9BDF);
    t_ram_read(2, 28'h17FFFFC, 2'd3, 32'hF0E1_D2C3);
    t_ram_write(28'h1800010, 2'd2, 32'h1122_3344);
    t_ram_write(28'h1000003, 2'd0, 32'hAABB_CCDE);
    t_ram_write(28'h1C00002, 2'd1, 32'h0000_9A5F);
    t_reject(1'b1, 28'h0000100, "R3");
    t_reject(1'b0, 28'h8000040, "R1");
    t_reject(1'b0, 28'h2000000, "R1");
    t_busy_ignore();
    do_reset(0);
    t_flash_read(0, 28'h0FFFFFF, 32'h0102_0304);
    t_ram_read(0, 28'h1800001, 2'd2, 32'h5566_7788);
    do_reset(3);
    t_flash_read(3, 28'h0000000, 32'hA1B2_C3D4);
    t_ram_read(3, 28'h1000000, 2'd1, 32'h0000_E4F5);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule